// File: doc/BRIEF.md
# Conversion Result Register Bank

This block keeps the most recent conversion result for each of eight sequence slots and lets a bus master read them. The conversion engine pushes a 12-bit code with a slot index on a one-cycle write strobe. The bank stores the code and sets a valid flag for that slot. If the slot already held an unread result, the bank also sets an overrun flag. Reading a slot returns a 32-bit word with the result, four extension bits and both flags. The read also clears both flags of that slot.

A format control selects how results are presented. In unsigned mode the raw code is kept as it arrives. In two's complement mode the code's MSB is inverted when it is captured, which maps offset binary onto a signed value. At read time the extension bits then copy the sign bit. The read port takes a word index n, which is the register at byte offset 4n. The read word appears on the clock edge after the read strobe, and the flags of that slot clear on that same edge.

Top module: `adc_result_bank`

## Requirements
- R1: A read word carries the stored 12-bit result in bits 11:0, the extension bits in 15:12, the overrun flag in bit 16 and the valid flag in bit 17. Bits 31:18 are always zero.
- R2: With the format input low (unsigned), a written code is stored unchanged, and the extension bits of a read word are zero.
- R3: With the format input high (two's complement) at write time, the stored result is the written code with bit 11 inverted. With the format input high at read time, the four extension bits all equal bit 11 of the stored result.
- R4: A write to slot n sets the valid flag of register n.
- R5: A write to slot n while its valid flag is set, and without a read of slot n in the same cycle, sets the overrun flag of register n. The flag stays set until register n is read.
- R6: A read strobe for word index n loads rd_data on the next clock edge with the contents of register n before clearing. On that same edge the valid and overrun flags of register n are cleared. The stored result is kept.
- R7: When a write and a read of the same slot fall in the same cycle, the read returns the old contents. The register then holds the new result with valid set and overrun clear.
- R8: Word index n (byte offset 4n) selects register n, which holds the result of sequence slot n. A write to slot n leaves every other register unchanged.
- R9: After reset every register, every flag and rd_data are zero.
- R10: rd_data holds its value in every cycle without a read strobe, whatever the write port and the format input do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Result write strobe from the conversion engine |
| wr_slot | input | 3 | Sequence slot of the result being written |
| wr_code | input | 12 | Raw conversion code |
| fmt_twos | input | 1 | Format control: 0 unsigned, 1 two's complement |
| rd_en | input | 1 | Read strobe |
| rd_word | input | 3 | Word index of the register read (byte offset / 4) |
| rd_data | output | 32 | Registered read word |

## Verification
The bench builds the block with its default parameters: eight slots, 12-bit results, four extension bits and a 32-bit read word. With these values every slot index and word index can be reached, and each register can be written and read on its own. This brings the slot decode, and the isolation between neighbouring registers, within reach. It also exposes the fixed flag positions at bits 16 and 17 that a reader decodes. Codes 0x123 and 0xFFF test both sign outcomes of the MSB inversion. The same-cycle write and read on one slot reaches the corner where the clear on read and the new capture meet.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Default geometry of the bank; modules take these as parameter defaults.
  localparam int unsigned SLOTS_DEF  = 8;
  localparam int unsigned RES_W_DEF  = 12;
  localparam int unsigned EXT_W_DEF  = 4;
  localparam int unsigned WORD_W_DEF = 32;

  // Flag state held per slot.
  typedef struct packed {
    logic valid;
    logic ovr;
  } slot_flags_t;
endpackage

// File: rtl/rb_fmt.sv
// Capture-side format conversion: offset binary to two's complement is an MSB flip.
module rb_fmt #(
  parameter int unsigned RES_W = rb_pkg::RES_W_DEF
) (
  input  logic [RES_W-1:0] raw,
  input  logic             twos,
  output logic [RES_W-1:0] code
);
  always_comb begin
    code = raw;
    if (twos) begin
      code[RES_W-1] = ~raw[RES_W-1];
    end
  end
endmodule

// File: rtl/rb_slot.sv
// One result register with its valid and overrun flags.
module rb_slot #(
  parameter int unsigned RES_W = rb_pkg::RES_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [RES_W-1:0]    wr_code,
  input  logic                rd_hit,
  output logic [RES_W-1:0]    code_q,
  output rb_pkg::slot_flags_t flags_q
);
  rb_pkg::slot_flags_t flags_d;
  logic                load_code;

  assign load_code = wr_hit;

  always_comb begin
    flags_d = flags_q;
    if (wr_hit && rd_hit) begin
      flags_d.valid = 1'b1;
      flags_d.ovr   = 1'b0;
    end else if (wr_hit) begin
      flags_d.ovr   = flags_q.ovr | flags_q.valid;
      flags_d.valid = 1'b1;
    end else if (rd_hit) begin
      flags_d.valid = 1'b0;
      flags_d.ovr   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load_code) begin
      code_q <= wr_code;
    end
  end

  // R4: a capture always leaves the slot valid
  a_r4_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> flags_q.valid);
  // R5: overwrite of an unread result marks overrun
  a_r5_ovr_on_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !rd_hit && flags_q.valid) |=> flags_q.ovr);
  // R5: overrun never exists without valid
  a_r5_ovr_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.ovr |-> flags_q.valid);
  // R6: a plain read clears both flags
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit) |=> (!flags_q.valid && !flags_q.ovr));
  // R7: same-cycle write and read leaves fresh data without overrun
  a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && wr_hit) |=> (flags_q.valid && !flags_q.ovr));
  // R8: the result changes only on a capture
  a_r8_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(code_q));
endmodule

// File: rtl/rb_rdpath.sv
// Read selection, word assembly and the registered read data.
module rb_rdpath #(
  parameter int unsigned SLOTS  = rb_pkg::SLOTS_DEF,
  parameter int unsigned RES_W  = rb_pkg::RES_W_DEF,
  parameter int unsigned EXT_W  = rb_pkg::EXT_W_DEF,
  parameter int unsigned WORD_W = rb_pkg::WORD_W_DEF,
  parameter int unsigned IDX_W  = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_word,
  input  logic                fmt_twos,
  input  logic [RES_W-1:0]    codes [SLOTS],
  input  rb_pkg::slot_flags_t flags [SLOTS],
  output logic [WORD_W-1:0]   rd_data
);
  localparam int unsigned OVR_POS = RES_W + EXT_W;
  localparam int unsigned VLD_POS = OVR_POS + 1;

  logic [RES_W-1:0]  sel_code;
  rb_pkg::slot_flags_t sel_flags;
  logic [EXT_W-1:0]  sel_ext;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    sel_code  = codes[rd_word];
    sel_flags = flags[rd_word];
    sel_ext   = fmt_twos ? {EXT_W{sel_code[RES_W-1]}} : '0;
    word_d    = '0;
    word_d[RES_W-1:0]       = sel_code;
    word_d[RES_W +: EXT_W]  = sel_ext;
    word_d[OVR_POS]         = sel_flags.ovr;
    word_d[VLD_POS]         = sel_flags.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= word_d;
    end
  end

  // R10: read data only moves on a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R1: bits above the valid flag stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:VLD_POS+1] == '0);
  // R2: unsigned reads carry no extension
  a_r2_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fmt_twos) |=> rd_data[RES_W +: EXT_W] == '0);
  // R1: overrun in a read word implies valid in that word
  a_r1_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[OVR_POS] |-> rd_data[VLD_POS]);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned SLOTS  = rb_pkg::SLOTS_DEF,
  parameter int unsigned RES_W  = rb_pkg::RES_W_DEF,
  parameter int unsigned EXT_W  = rb_pkg::EXT_W_DEF,
  parameter int unsigned WORD_W = rb_pkg::WORD_W_DEF,
  parameter int unsigned IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [RES_W-1:0]  wr_code,
  input  logic              fmt_twos,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data
);
  logic [RES_W-1:0]    cap_code;
  logic [RES_W-1:0]    codes [SLOTS];
  rb_pkg::slot_flags_t flags [SLOTS];
  logic [SLOTS-1:0]    wr_hit;
  logic [SLOTS-1:0]    rd_hit;

  rb_fmt #(.RES_W(RES_W)) u_fmt (
    .raw  (wr_code),
    .twos (fmt_twos),
    .code (cap_code)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign wr_hit[g] = wr_en && (wr_slot == IDX_W'(g));
    assign rd_hit[g] = rd_en && (rd_word == IDX_W'(g));

    rb_slot #(.RES_W(RES_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[g]),
      .wr_code (cap_code),
      .rd_hit  (rd_hit[g]),
      .code_q  (codes[g]),
      .flags_q (flags[g])
    );
  end

  rb_rdpath #(
    .SLOTS (SLOTS), .RES_W (RES_W), .EXT_W (EXT_W),
    .WORD_W(WORD_W), .IDX_W (IDX_W)
  ) u_rdpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .fmt_twos (fmt_twos),
    .codes    (codes),
    .flags    (flags),
    .rd_data  (rd_data)
  );

  // R8: at most one slot is targeted per strobe
  a_r8_one_hot_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  a_r8_one_hot_read: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));
endmodule

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_slot;
  logic [11:0] wr_code;
  logic        fmt_twos;
  logic        rd_en;
  logic [2:0]  rd_word;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  adc_result_bank i_adc_result_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_code(wr_code), .fmt_twos(fmt_twos), .rd_en(rd_en),
    .rd_word(rd_word), .rd_data(rd_data)
  );

  function automatic logic [31:0] mk(logic [11:0] c, bit tw, bit o, bit v);
    logic [31:0] r;
    r = '0;
    r[11:0]  = c;
    r[15:12] = tw ? {4{c[11]}} : 4'h0;
    r[16]    = o;
    r[17]    = v;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [11:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = s; wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_word = s;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 rd_data after reset", rd_data, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R9 register zero after reset", d, 32'h0);
    end
  endtask

  task automatic t_unsigned();
    logic [31:0] d;
    fmt_twos = 1'b0;
    wr(3'd3, 12'hABC);
    rd(3'd3, d);
    chk("R2 R4 unsigned capture", d, mk(12'hABC, 0, 0, 1));
    chk("R1 upper bits zero", {18'h0, d[31:18]}, 32'h0);
    rd(3'd3, d);
    chk("R6 flags cleared, result kept", d, mk(12'hABC, 0, 0, 0));
  endtask

  task automatic t_twos();
    logic [31:0] d;
    fmt_twos = 1'b1;
    wr(3'd5, 12'h123);
    rd(3'd5, d);
    chk("R3 twos negative", d, 32'h0002F923);
    wr(3'd5, 12'hFFF);
    rd(3'd5, d);
    chk("R3 twos positive", d, 32'h000207FF);
    fmt_twos = 1'b0;
    rd(3'd5, d);
    chk("R2 unsigned read of stored code", d, mk(12'h7FF, 0, 0, 0));
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    fmt_twos = 1'b0;
    wr(3'd0, 12'h111);
    wr(3'd0, 12'h222);
    wr(3'd0, 12'h333);
    rd(3'd0, d);
    chk("R5 overrun set", d, mk(12'h333, 0, 1, 1));
    rd(3'd0, d);
    chk("R6 overrun cleared by read", d, mk(12'h333, 0, 0, 0));
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    fmt_twos = 1'b0;
    wr(3'd2, 12'h0AA);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = 3'd2; wr_code = 12'h0BB;
    rd_en = 1'b1; rd_word = 3'd2;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R7 read returns old", rd_data, mk(12'h0AA, 0, 0, 1));
    rd(3'd2, d);
    chk("R7 new valid, no overrun", d, mk(12'h0BB, 0, 0, 1));
  endtask

  task automatic t_addr();
    logic [31:0] d;
    fmt_twos = 1'b0;
    for (int i = 0; i < 8; i++) wr(3'(i), 12'h100 + 12'(i * 17));
    for (int i = 7; i >= 0; i--) begin
      rd(3'(i), d);
      chk("R8 slot isolation", d, mk(12'h100 + 12'(i * 17), 0, 0, 1));
    end
  endtask

  task automatic t_hold();
    logic [31:0] d;
    logic [31:0] snap;
    fmt_twos = 1'b0;
    wr(3'd6, 12'h456);
    rd(3'd6, snap);
    chk("R6 read of slot 6", snap, mk(12'h456, 0, 0, 1));
    wr(3'd1, 12'h789);
    @(negedge clk);
    fmt_twos = 1'b1;
    rd_word = 3'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold without strobe", rd_data, snap);
    fmt_twos = 1'b0;
    rd(3'd1, d);
    chk("R4 slot 1 still valid", d, mk(12'h789, 0, 0, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_slot = '0; wr_code = '0;
    fmt_twos = 1'b0; rd_en = 1'b0; rd_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unsigned();
    t_twos();
    t_overrun();
    t_same_cycle();
    t_addr();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule